// File: doc/BRIEF.md
# Parcelized Word Output Channel

This block is an output channel controller of the direct-memory-access kind. A start pulse loads a current address and a limit address. The channel then reads 64-bit words from a request/valid memory read port, starting at the current address. After each word is read, the address moves up by one.

Each word goes to an external device as four 16-bit parcels, with the most significant parcel first. Every parcel comes with a one-cycle Ready pulse and four odd-parity bits. The channel waits for a Resume pulse from the device before it sends the next parcel. The word read when the advanced address reaches the limit is the last word. Its first parcel carries a Disconnect flag. Once that word has finished, the channel raises an interrupt and goes idle.

A master clear can come from a programmed bit or from a global I/O clear. It is passed to the device as a static level and returns the channel to idle.

Top module: `pwo_channel`

## Requirements
- R1: A start pulse while the channel is idle and no clear is present loads both addresses. In the next cycle, active is high and mem_req is high with mem_addr equal to the loaded start address. A start pulse while the channel is active has no effect on the transfer in progress.
- R2: mem_req stays high until mem_valid is seen. Each accepted word advances the current address by one, so that successive words come from consecutive addresses.
- R3: The parcels of a word go out in the order bits 63..48, 47..32, 31..16 and 15..0 on dev_data.
- R4: Every parcel is launched with dev_ready high for exactly one cycle. The first parcel of a word is launched in the cycle after mem_valid is accepted.
- R5: dev_data and dev_parity hold their values from one Ready pulse until the next parcel is launched. The next parcel is launched in the cycle after an accepted Resume.
- R6: dev_parity[k] gives odd parity over dev_data[4k+3:4k], for k from 0 to 3.
- R7: dev_disconnect is high from the first parcel of the last word until the next parcel is launched, and low for every other parcel. The last word is the one where the advanced address equals the limit. The Resume that follows the fourth parcel of the last word sets irq and clears active. Any other such Resume starts the next fetch.
- R8: A Resume is ignored while the channel is idle, while it is fetching, and in the cycle in which dev_ready is high. The parcel on the outputs does not change, and no new Ready pulse follows.
- R9: dev_clear equals prog_clear OR io_clear. While either clear input is high, the channel returns to idle at the next edge and drives dev_ready and dev_disconnect low. While a clear is high, irq is cleared and start is ignored.
- R10: A start with the start address equal to the limit address makes no memory request. It sets irq at the next edge and leaves active low.
- R11: irq stays high until the next accepted start or a clear.
- R12: After reset, active, irq, mem_req, dev_ready, dev_disconnect and dev_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, loads the addresses |
| start_addr | input | 16 | First word address |
| limit_addr | input | 16 | Limit address |
| prog_clear | input | 1 | Programmed master clear level |
| io_clear | input | 1 | Global I/O clear level |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address (current address) |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 64 | Read data |
| dev_data | output | 16 | Parcel data to the device |
| dev_parity | output | 4 | Per-nibble odd parity |
| dev_ready | output | 1 | One-cycle parcel strobe |
| dev_disconnect | output | 1 | Last-word flag |
| dev_resume | input | 1 | Device acknowledge pulse |
| dev_clear | output | 1 | Static master clear to the device |
| irq | output | 1 | Transfer complete flag |
| active | output | 1 | Channel busy |

## Verification
The end of a transfer and a master clear can fall in the same cycle: the final Resume after the fourth parcel of the last word would set irq at the same edge at which the clear resets the channel. The bench provokes this by raising dev_resume and io_clear together at the same falling edge, after the last parcel has been observed. It judges the result one edge later: irq must remain low, active must be low and dev_clear must be high, because the clear takes priority over completion.

// File: rtl/pwo_pkg.sv
package pwo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } pwo_state_e;
endpackage

// File: rtl/pwo_parity.sv
module pwo_parity #(
    parameter int PARCEL_W = 16,
    parameter int NIB_W    = 4,
    localparam int NPAR    = PARCEL_W / NIB_W
) (
    input  logic [PARCEL_W-1:0] data,
    output logic [NPAR-1:0]     par
);
    // Each bit makes its nibble plus itself carry an odd number of ones.
    for (genvar k = 0; k < NPAR; k++) begin : g_nib
        assign par[k] = ~^data[k*NIB_W +: NIB_W];
    end
endmodule

// File: rtl/pwo_addr.sv
module pwo_addr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] limit_addr,
    output logic [ADDR_W-1:0] cur,
    output logic              next_hits_limit,
    output logic              empty_range
);
    typedef struct packed {
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] lim;
    } addr_regs_t;

    addr_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.cur = start_addr;
            r_d.lim = limit_addr;
        end else if (advance) begin
            r_d.cur = r_q.cur + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cur             = r_q.cur;
    assign next_hits_limit = (ADDR_W'(r_q.cur + 1'b1) == r_q.lim);
    assign empty_range     = (start_addr == limit_addr);

    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (r_q.cur == ADDR_W'($past(r_q.cur) + 1'b1))); // R2
    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (r_q.cur == $past(start_addr))); // R1
endmodule

// File: rtl/pwo_seq.sv
module pwo_seq
    import pwo_pkg::*;
#(
    parameter int WORD_W   = 64,
    parameter int PARCEL_W = 16,
    localparam int NPARCEL = WORD_W / PARCEL_W,
    localparam int IDX_W   = (NPARCEL > 1) ? $clog2(NPARCEL) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                start,
    input  logic                empty_range,
    input  logic                next_hits_limit,
    input  logic                mem_valid,
    input  logic [WORD_W-1:0]   mem_data,
    input  logic                resume,
    output logic                load,
    output logic                advance,
    output logic                mem_req,
    output logic [PARCEL_W-1:0] data,
    output logic                ready,
    output logic                disc,
    output logic                irq,
    output logic                active
);
    typedef struct packed {
        pwo_state_e          st;
        logic [IDX_W-1:0]    idx;
        logic [WORD_W-1:0]   word;
        logic [PARCEL_W-1:0] data;
        logic                ready;
        logic                disc;
        logic                last;
        logic                irq;
    } seq_regs_t;

    seq_regs_t s_q, s_d;

    function automatic logic [PARCEL_W-1:0] pick(input logic [WORD_W-1:0] w,
                                                 input logic [IDX_W-1:0]  i);
        logic [WORD_W-1:0] sh;
        sh = w >> (PARCEL_W * (NPARCEL - 1 - int'(i)));
        return sh[PARCEL_W-1:0];
    endfunction

    always_comb begin
        s_d       = s_q;
        s_d.ready = 1'b0;
        load      = 1'b0;
        advance   = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    load      = 1'b1;
                    s_d.irq   = empty_range;
                    s_d.st    = empty_range ? ST_IDLE : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_valid) begin
                    advance   = 1'b1;
                    s_d.word  = mem_data;
                    s_d.idx   = '0;
                    s_d.data  = pick(mem_data, '0);
                    s_d.ready = 1'b1;
                    s_d.disc  = next_hits_limit;
                    s_d.last  = next_hits_limit;
                    s_d.st    = ST_WAIT;
                end
            end
            ST_WAIT: begin
                // A Resume counts only after the Ready pulse has ended.
                if (resume && !s_q.ready) begin
                    if (s_q.idx == IDX_W'(NPARCEL - 1)) begin
                        if (s_q.last) begin
                            s_d.irq = 1'b1;
                            s_d.st  = ST_IDLE;
                        end else begin
                            s_d.st  = ST_FETCH;
                        end
                    end else begin
                        s_d.idx   = IDX_W'(s_q.idx + 1'b1);
                        s_d.data  = pick(s_q.word, IDX_W'(s_q.idx + 1'b1));
                        s_d.ready = 1'b1;
                        s_d.disc  = 1'b0;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        // A master clear has priority over start, fetch and completion.
        if (clr) begin
            s_d.st    = ST_IDLE;
            s_d.idx   = '0;
            s_d.ready = 1'b0;
            s_d.disc  = 1'b0;
            s_d.irq   = 1'b0;
            load      = 1'b0;
            advance   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign mem_req = (s_q.st == ST_FETCH);
    assign data    = s_q.data;
    assign ready   = s_q.ready;
    assign disc    = s_q.disc;
    assign irq     = s_q.irq;
    assign active  = (s_q.st != ST_IDLE);

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R4
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> $stable(data)); // R5
    AST_FETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid && !clr) |=> mem_req); // R2
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !active); // R7
    AST_CLEAR_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!active && !irq && !ready)); // R9
endmodule

// File: rtl/pwo_channel.sv
module pwo_channel #(
    parameter int ADDR_W   = 16,
    parameter int WORD_W   = 64,
    parameter int PARCEL_W = 16,
    parameter int NIB_W    = 4,
    localparam int NPAR    = PARCEL_W / NIB_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [ADDR_W-1:0]   limit_addr,
    input  logic                prog_clear,
    input  logic                io_clear,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_valid,
    input  logic [WORD_W-1:0]   mem_data,
    output logic [PARCEL_W-1:0] dev_data,
    output logic [NPAR-1:0]     dev_parity,
    output logic                dev_ready,
    output logic                dev_disconnect,
    input  logic                dev_resume,
    output logic                dev_clear,
    output logic                irq,
    output logic                active
);
    logic clr, load, advance, next_hits_limit, empty_range;

    assign clr       = prog_clear | io_clear;
    assign dev_clear = clr;

    pwo_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk             (clk),
        .rst_n           (rst_n),
        .load            (load),
        .advance         (advance),
        .start_addr      (start_addr),
        .limit_addr      (limit_addr),
        .cur             (mem_addr),
        .next_hits_limit (next_hits_limit),
        .empty_range     (empty_range)
    );

    pwo_seq #(.WORD_W(WORD_W), .PARCEL_W(PARCEL_W)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .clr             (clr),
        .start           (start),
        .empty_range     (empty_range),
        .next_hits_limit (next_hits_limit),
        .mem_valid       (mem_valid),
        .mem_data        (mem_data),
        .resume          (dev_resume),
        .load            (load),
        .advance         (advance),
        .mem_req         (mem_req),
        .data            (dev_data),
        .ready           (dev_ready),
        .disc            (dev_disconnect),
        .irq             (irq),
        .active          (active)
    );

    pwo_parity #(.PARCEL_W(PARCEL_W), .NIB_W(NIB_W)) u_par (
        .data (dev_data),
        .par  (dev_parity)
    );

    for (genvar k = 0; k < NPAR; k++) begin : g_par_chk
        AST_PARITY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
            ^{dev_data[k*NIB_W +: NIB_W], dev_parity[k]}); // R6
    end

    AST_DISC_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_disconnect) |-> dev_ready); // R7
endmodule

// File: tb/tb_pwo_channel.sv
module tb_pwo_channel;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, prog_clear, io_clear, mem_valid, dev_resume;
    logic [15:0] start_addr, limit_addr;
    logic [63:0] mem_data;
    logic        mem_req, dev_ready, dev_disconnect, dev_clear, irq, active;
    logic [15:0] mem_addr, dev_data;
    logic [3:0]  dev_parity;

    int n_chk = 0, n_bad = 0, mem_lat = 0, lat_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwo_channel dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .limit_addr(limit_addr), .prog_clear(prog_clear), .io_clear(io_clear),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_data(mem_data), .dev_data(dev_data), .dev_parity(dev_parity),
        .dev_ready(dev_ready), .dev_disconnect(dev_disconnect),
        .dev_resume(dev_resume), .dev_clear(dev_clear), .irq(irq), .active(active)
    );

    function automatic logic [63:0] wexp(input logic [15:0] a);
        return {a ^ 16'h1234, ~a, 16'(a * 3), 16'(a + 16'h00FF)};
    endfunction

    function automatic logic [3:0] pexp(input logic [15:0] d);
        logic [3:0] p;
        for (int k = 0; k < 4; k++) p[k] = ~^d[4*k +: 4];
        return p;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: answers a request after mem_lat waiting cycles.
    initial begin
        mem_valid = 1'b0;
        mem_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_valid) mem_valid = 1'b0;
            else if (mem_req) begin
                if (lat_cnt >= mem_lat) begin
                    mem_valid = 1'b1;
                    mem_data  = wexp(mem_addr);
                    lat_cnt   = 0;
                end else lat_cnt++;
            end else lat_cnt = 0;
        end
    end

    task automatic wait_ready();
        int n = 0;
        while (!dev_ready && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(dev_ready, "R4 ready pulse expected", dev_ready, 1);
    endtask

    task automatic pulse_resume();
        @(negedge clk);
        dev_resume = 1'b1;
        @(negedge clk);
        dev_resume = 1'b0;
    endtask

    task automatic start_xfer(input logic [15:0] a, input logic [15:0] l);
        @(negedge clk);
        start_addr = a; limit_addr = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Receives one word; the resume after the fourth parcel is optional.
    task automatic recv_word(input logic [15:0] a, input bit last, input int dly,
                             input bit final_resume);
        logic [63:0] w = wexp(a);
        for (int p = 0; p < 4; p++) begin
            logic [15:0] ep = w[63 - 16*p -: 16];
            wait_ready();
            check(dev_data == ep, "R3 parcel data", dev_data, ep);
            check(dev_parity == pexp(ep), "R6 parity", dev_parity, pexp(ep));
            check(dev_disconnect == (last && p == 0), "R7 disconnect",
                  dev_disconnect, (last && p == 0));
            for (int d = 0; d < dly; d++) begin
                @(negedge clk);
                check(!dev_ready && dev_data == ep, "R5 parcel held", dev_data, ep);
            end
            if (p < 3 || final_resume) pulse_resume();
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 0; prog_clear = 0; io_clear = 0; dev_resume = 0;
        start_addr = '0; limit_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({active, irq, mem_req, dev_ready, dev_disconnect} == 0 && dev_data == 0,
              "R12 reset state", {active, irq, mem_req, dev_ready, dev_disconnect}, 0);
    endtask

    task automatic t_multi_word();
        mem_lat = 0;
        start_xfer(16'h0010, 16'h0013);
        check(active && mem_req && mem_addr == 16'h0010, "R1 fetch starts at start address",
              mem_addr, 16'h0010);
        for (int i = 0; i < 3; i++) recv_word(16'h0010 + 16'(i), i == 2, 0, 1);
        check(irq && !active && !mem_req, "R7 irq after last word", {irq, active}, 2'b10);
        repeat (4) @(negedge clk);
        check(irq, "R11 irq holds while idle", irq, 1);
    endtask

    task automatic t_slow_and_ignored();
        mem_lat = 3;
        @(negedge clk);
        dev_resume = 1'b1;                    // idle resume
        @(negedge clk);
        dev_resume = 1'b0;
        check(!active && !dev_ready, "R8 idle resume ignored", active, 0);
        start_xfer(16'h0100, 16'h0101);
        check(!irq, "R11 start clears irq", irq, 0);
        dev_resume = 1'b1;                    // resume during fetch
        @(negedge clk);
        dev_resume = 1'b0;
        check(mem_req && !dev_ready, "R2 request held during latency", mem_req, 1);
        wait_ready();
        dev_resume = 1'b1;                    // resume in the Ready cycle
        @(negedge clk);
        dev_resume = 1'b0;
        repeat (3) @(negedge clk);
        check(!dev_ready && dev_data == wexp(16'h0100)[63:48], "R8 ready-cycle resume ignored",
              dev_data, wexp(16'h0100)[63:48]);
        pulse_resume();
        begin
            logic [63:0] w = wexp(16'h0100);
            for (int p = 1; p < 4; p++) begin
                wait_ready();
                check(dev_data == w[63 - 16*p -: 16], "R3 parcel data slow",
                      dev_data, w[63 - 16*p -: 16]);
                check(!dev_disconnect, "R7 disconnect only first parcel", dev_disconnect, 0);
                repeat (2) @(negedge clk);
                check(dev_data == w[63 - 16*p -: 16], "R5 hold before resume",
                      dev_data, w[63 - 16*p -: 16]);
                pulse_resume();
            end
        end
        check(irq && !active, "R7 single word completes", {irq, active}, 2'b10);
    endtask

    task automatic t_start_while_active();
        mem_lat = 1;
        start_xfer(16'h0200, 16'h0202);
        wait_ready();
        @(negedge clk);
        start_addr = 16'h0500; limit_addr = 16'h0600; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pulse_resume();
        for (int p = 1; p < 4; p++) begin
            wait_ready();
            check(dev_data == wexp(16'h0200)[63 - 16*p -: 16], "R1 start ignored when active",
                  dev_data, wexp(16'h0200)[63 - 16*p -: 16]);
            pulse_resume();
        end
        check(mem_addr == 16'h0201, "R2 address advanced by one", mem_addr, 16'h0201);
        recv_word(16'h0201, 1, 1, 1);
        check(irq && !active, "R7 done after two words", {irq, active}, 2'b10);
    endtask

    task automatic t_clear();
        mem_lat = 0;
        start_xfer(16'h0300, 16'h0308);
        wait_ready();
        pulse_resume();
        wait_ready();
        @(negedge clk);
        prog_clear = 1'b1;
        #1 check(dev_clear, "R9 clear passed to device", dev_clear, 1);
        @(negedge clk);
        start = 1'b1; start_addr = 16'h0400; limit_addr = 16'h0402;
        check(!active && !dev_ready && !dev_disconnect && !mem_req && !irq,
              "R9 channel idles on clear", active, 0);
        @(negedge clk);
        start = 1'b0;
        check(!active && !mem_req, "R9 start ignored under clear", active, 0);
        prog_clear = 1'b0;
        @(negedge clk);
        check(!dev_clear, "R9 clear released", dev_clear, 0);
    endtask

    task automatic t_empty_range();
        start_xfer(16'h0030, 16'h0030);
        check(irq && !active && !mem_req, "R10 equal addresses finish at once",
              {irq, active, mem_req}, 3'b100);
    endtask

    task automatic t_clear_vs_done();
        mem_lat = 0;
        start_xfer(16'h0700, 16'h0701);
        check(!irq, "R11 irq cleared by start", irq, 1'b0);
        recv_word(16'h0700, 1, 0, 0);
        @(negedge clk);
        dev_resume = 1'b1; io_clear = 1'b1;
        @(negedge clk);
        dev_resume = 1'b0;
        check(!irq && !active && dev_clear, "R9 clear wins over final resume",
              {irq, active, dev_clear}, 3'b001);
        io_clear = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_multi_word();
        t_slow_and_ignored();
        t_start_while_active();
        t_clear();
        t_empty_range();
        t_clear_vs_done();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule